// File: doc/BRIEF.md
# System Clock Source Selector with Oscillator-Ready Timers

This block decides which clock paces a small microcontroller core. One 8-bit control register chooses the source: the undivided high-speed oscillator, the high-speed oscillator divided by a power of two from 2 to 64, or the low-speed oscillator. The block also tracks whether each oscillator has settled since power-on or since the last wake-up. It does this by counting oscillator cycles up to a limit that depends on whether the oscillator is a crystal or an RC type.

The whole block runs in one clock domain. Each oscillator edge arrives as a single-cycle tick enable, `hs_tick` or `ls_tick`. The chosen system clock leaves as a single-cycle enable, `sys_en`, so no real clock is ever multiplexed. A power-mode input tells the block which oscillators are stopped. The mode codes are run, idle (high-speed stopped) and sleep (both stopped).

A fast-wake option lets a core with a crystal high-speed source run from the low-speed clock while the crystal settles after a wake-up. The core moves to the high-speed source once it is ready.

Top module: `sysclk_sel_unit`

## Requirements
- R1: After reset the register reads 8'h03. The layout is: select field in bits 7:5, fast-wake enable in bit 4, low-speed ready in bit 3, high-speed ready in bit 2, idle enable in bit 1, and high/low mode in bit 0. All fields read 0 except bits 1 and 0, which read 1.
- R2: A write stores bits 7:4, 1 and 0 at the next clock edge. Written values in bits 3 and 2 are ignored, and those bits always read the live ready flags.
- R3: With mode bit 1 set, `sys_en` pulses on every high-speed tick. With mode bit 0 clear, select codes 0 and 1 pulse on low-speed ticks. Codes 2 to 7 divide the high-speed ticks by 64, 32, 16, 8, 4 and 2. A free-running 6-bit counter, cleared at reset and advanced by each high-speed tick, drives the division. For a divide-by-2^k source, the pulse falls on the tick where the counter's low k bits are all ones. `sys_en` is never high without a tick of the source in use.
- R4: A new source choice from the register takes effect only at the high-speed tick where the 6-bit counter holds 63. That tick is still paced by the old source, and the new source applies from the next cycle.
- R5: The high-speed ready flag is 0 after reset and clears whenever the power mode is not run. In run mode it counts high-speed ticks and reads 1 from the cycle after the 1024th tick (crystal) or the 16th tick (RC).
- R6: The low-speed ready flag is 0 after reset and clears in sleep. In run or idle it counts low-speed ticks and reads 1 from the cycle after the 1024th tick (crystal) or the 2nd tick (RC).
- R7: While the ready flag of the source in use is 0, `sys_en` stays low. The one exception is the case covered by R8.
- R8: If fast-wake is enabled, the high-speed oscillator is a crystal, a high-speed source is in use and the high-speed flag is 0, then `sys_en` follows low-speed ticks, gated by the low-speed ready flag.
- R9: `sys_en` is low whenever the power mode is not run.
- R10: Power mode codes: 00 is run, 01 is idle (the high-speed oscillator stops and the low-speed oscillator keeps running and counting), and 10 and 11 are sleep (both stop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_tick | input | 1 | One-cycle pulse per high-speed oscillator edge |
| ls_tick | input | 1 | One-cycle pulse per low-speed oscillator edge |
| hs_is_xtal | input | 1 | Static: high-speed oscillator is a crystal (1) or RC (0) |
| ls_is_xtal | input | 1 | Static: low-speed oscillator is a crystal (1) or RC (0) |
| pwr_mode | input | 2 | 00 run, 01 idle, 10/11 sleep |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, including the live ready flags |
| sys_en | output | 1 | System clock enable pulse |

## Verification
A wrong divider count or a stale active-source register shows up first as a `sys_en` pulse on the wrong high-speed tick. With divide-by-64 this can take up to 64 ticks to appear, and the bench compares every cycle over several full counter wraps for each select code. A ready counter with the wrong limit moves the rising edge of bit 2 or bit 3 in the read data by at least one cycle, and `sys_en` moves with it. A fast-wake fault appears as `sys_en` pulses in the crystal wake-up window that follow the wrong tick stream.

// File: rtl/sysclk_sel_pkg.sv
// Package: shared types, field positions and source decode for the system
// clock selector. Assumes the division range is fixed at 2 to 64.
package sysclk_sel_pkg;

    localparam int DIV_BITS = 6;              // counter bits: largest divide is 2^6
    localparam int SHIFT_W  = $clog2(DIV_BITS + 1);

    localparam int BIT_HL    = 0;
    localparam int BIT_IDLE  = 1;
    localparam int BIT_HSRDY = 2;
    localparam int BIT_LSRDY = 3;
    localparam int BIT_FAST  = 4;
    localparam int SEL_LSB   = 5;
    localparam int SEL_W     = 3;

    typedef enum logic [1:0] {
        PWR_RUN    = 2'b00,
        PWR_IDLE   = 2'b01,
        PWR_SLEEP  = 2'b10,
        PWR_SLEEP2 = 2'b11
    } pwr_mode_e;

    // Which clock paces the core: low-speed, or high-speed divided by 2^shift.
    typedef struct packed {
        logic               use_ls;
        logic [SHIFT_W-1:0] shift;
    } src_sel_t;

    // Map mode bit and select code to a source.
    function automatic src_sel_t decode_src(input logic hl, input logic [SEL_W-1:0] sel);
        src_sel_t   s;
        logic [3:0] k;
        k        = 4'd8 - {1'b0, sel};
        s.use_ls = 1'b0;
        s.shift  = '0;
        if (!hl) begin
            if (sel < 3'd2) s.use_ls = 1'b1;
            else            s.shift  = k[SHIFT_W-1:0];
        end
        return s;
    endfunction

endpackage

// File: rtl/osc_ready_timer.sv
// Oscillator-ready timer: counts oscillator ticks while the oscillator is
// powered and raises `ready` after a crystal- or RC-dependent number of
// ticks. Assumes is_xtal is static while powered.
module osc_ready_timer #(
    parameter int XTAL_CYC = 1024,
    parameter int RC_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic powered,
    input  logic tick,
    input  logic is_xtal,
    output logic ready
);
    localparam int MAXC = (XTAL_CYC > RC_CYC) ? XTAL_CYC : RC_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Final count value for the configured oscillator type.
    assign last = is_xtal ? CW'(XTAL_CYC - 1) : CW'(RC_CYC - 1);

    // Settling counter: cleared while stopped, holds once ready.
    always_ff @(posedge clk) begin
        if (!rst_n || !powered) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (tick && !ready) begin
            if (cnt_q == last) ready <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hs_prescaler.sv
// High-speed prescaler: free-running counter advanced by high-speed ticks.
// Gives a pulse for a divide by 2^shift and a wrap strobe that marks the
// boundary common to every division period.
module hs_prescaler
    import sysclk_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [SHIFT_W-1:0] shift,
    output logic               pulse,
    output logic               wrap
);
    logic [DIV_BITS-1:0] cnt_q;
    logic [DIV_BITS-1:0] mask;

    // Tick counter, free-running from reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // The low `shift` bits all ones mark the last tick of a period.
    always_comb begin
        mask  = ~({DIV_BITS{1'b1}} << shift);
        pulse = tick && ((cnt_q & mask) == mask);
        wrap  = tick && (&cnt_q);
    end
endmodule

// File: rtl/clk_mode_reg.sv
// Clock-mode control register: stores the writable fields and assembles
// the read word with the live ready flags. Writes to the flag positions
// are dropped.
module clk_mode_reg
    import sysclk_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             hs_rdy,
    input  logic             ls_rdy,
    output logic [SEL_W-1:0] sel,
    output logic             fast_en,
    output logic             hl_mode,
    output logic [7:0]       rdata
);
    logic idle_en;

    // Writable fields; reset leaves high-speed mode and idle enable set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel     <= '0;
            fast_en <= 1'b0;
            idle_en <= 1'b1;
            hl_mode <= 1'b1;
        end else if (wr) begin
            sel     <= wdata[SEL_LSB +: SEL_W];
            fast_en <= wdata[BIT_FAST];
            idle_en <= wdata[BIT_IDLE];
            hl_mode <= wdata[BIT_HL];
        end
    end

    // Read word: stored fields plus live flags.
    always_comb begin
        rdata                   = '0;
        rdata[SEL_LSB +: SEL_W] = sel;
        rdata[BIT_FAST]         = fast_en;
        rdata[BIT_LSRDY]        = ls_rdy;
        rdata[BIT_HSRDY]        = hs_rdy;
        rdata[BIT_IDLE]         = idle_en;
        rdata[BIT_HL]           = hl_mode;
    end
endmodule

// File: rtl/sysclk_sel_unit.sv
// System clock selector top: register, prescaler, two ready timers and
// the source multiplexer producing the sys_en pulse. The source in use
// changes only at the prescaler wrap. Assumes tick inputs are one-cycle.
module sysclk_sel_unit
    import sysclk_sel_pkg::*;
#(
    parameter int HS_XTAL_CYC = 1024,
    parameter int HS_RC_CYC   = 16,
    parameter int LS_XTAL_CYC = 1024,
    parameter int LS_RC_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_tick,
    input  logic       ls_tick,
    input  logic       hs_is_xtal,
    input  logic       ls_is_xtal,
    input  logic [1:0] pwr_mode,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sys_en
);
    pwr_mode_e        mode;
    logic             run, ls_on;
    logic             hs_rdy, ls_rdy;
    logic [SEL_W-1:0] sel;
    logic             fast_en, hl_mode;
    logic             div_pulse, div_wrap;
    src_sel_t         req, act_q;
    logic             fast_sub;

    // Power-mode decode: idle stops high-speed only, sleep stops both.
    always_comb begin
        mode  = pwr_mode_e'(pwr_mode);
        run   = (mode == PWR_RUN);
        ls_on = (mode == PWR_RUN) || (mode == PWR_IDLE);
    end

    clk_mode_reg i_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .hs_rdy(hs_rdy), .ls_rdy(ls_rdy), .sel(sel), .fast_en(fast_en),
        .hl_mode(hl_mode), .rdata(reg_rdata)
    );

    osc_ready_timer #(.XTAL_CYC(HS_XTAL_CYC), .RC_CYC(HS_RC_CYC)) i_hs_rdy (
        .clk(clk), .rst_n(rst_n), .powered(run), .tick(hs_tick),
        .is_xtal(hs_is_xtal), .ready(hs_rdy)
    );

    osc_ready_timer #(.XTAL_CYC(LS_XTAL_CYC), .RC_CYC(LS_RC_CYC)) i_ls_rdy (
        .clk(clk), .rst_n(rst_n), .powered(ls_on), .tick(ls_tick),
        .is_xtal(ls_is_xtal), .ready(ls_rdy)
    );

    hs_prescaler i_div (
        .clk(clk), .rst_n(rst_n), .tick(hs_tick), .shift(act_q.shift),
        .pulse(div_pulse), .wrap(div_wrap)
    );

    // Requested source from the register fields.
    assign req = decode_src(hl_mode, sel);

    // Source in use: reloaded only at the common period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        act_q <= '0;
        else if (div_wrap) act_q <= req;
    end

    // Fast-wake substitution and the output enable.
    always_comb begin
        fast_sub = fast_en && hs_is_xtal && !act_q.use_ls && !hs_rdy;
        if (!run)
            sys_en = 1'b0;
        else if (act_q.use_ls || fast_sub)
            sys_en = ls_tick && ls_rdy;
        else
            sys_en = div_pulse && hs_rdy;
    end
endmodule

// File: rtl/sysclk_sel_chk.sv
// Checker for sysclk_sel_unit, bound to every instance of it. Observes
// ports only.
module sysclk_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_tick,
    input logic       ls_tick,
    input logic [1:0] pwr_mode,
    input logic [7:0] reg_rdata,
    input logic       sys_en
);
    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> reg_rdata == 8'h03); // R1
    AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |-> (hs_tick || ls_tick)); // R3
    AST_HS_RDY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != 2'b00) |=> !reg_rdata[2]); // R5
    AST_HS_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[2]) |-> $past(hs_tick)); // R5
    AST_LS_RDY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode[1] |=> !reg_rdata[3]); // R6
    AST_NO_EN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != 2'b00) |-> !sys_en); // R9
    AST_LS_KEPT_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'b01 && reg_rdata[3]) |=> reg_rdata[3]); // R10
endmodule

bind sysclk_sel_unit sysclk_sel_chk i_chk (.*);

// File: tb/test_sysclk_sel_unit.sv
// Scoreboard bench: the driver computes expected outputs from a model of
// the requirements and queues them; the monitor compares after each drive.
module test_sysclk_sel_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_tick = 1'b0, ls_tick = 1'b0;
    logic       hs_is_xtal = 1'b0, ls_is_xtal = 1'b0;
    logic [1:0] pwr_mode = 2'b00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sys_en;

    sysclk_sel_unit i_sysclk_sel_unit (
        .clk(clk), .rst_n(rst_n), .hs_tick(hs_tick), .ls_tick(ls_tick),
        .hs_is_xtal(hs_is_xtal), .ls_is_xtal(ls_is_xtal), .pwr_mode(pwr_mode),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_en(sys_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic en; logic [7:0] rd; string req; } item_t;
    item_t q[$];
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Model state
    int m_cnt = 0, m_k = 0, m_hsc = 0, m_lsc = 0;
    bit m_als = 0, m_hsr = 0, m_lsr = 0;
    bit [2:0] m_sel = 0;
    bit m_fast = 0, m_idle = 1, m_hl = 1;

    task automatic step(input bit hs, input bit ls, input bit [1:0] md,
                        input bit wr, input bit [7:0] wd, input string req);
        item_t it;
        int per, hlim, llim;
        bit en;
        @(negedge clk);
        hs_tick = hs; ls_tick = ls; pwr_mode = md; reg_wr = wr; reg_wdata = wd;
        per = 1 << m_k;
        if (md != 2'b00)                              en = 0;
        else if (m_als || (m_fast && hs_is_xtal && !m_hsr)) en = ls && m_lsr;
        else                                          en = hs && m_hsr && (((m_cnt + 1) % per) == 0);
        it.en = en;
        it.rd = {m_sel, m_fast, m_lsr, m_hsr, m_idle, m_hl};
        it.req = req;
        q.push_back(it);
        // advance model to the next edge
        if (hs && m_cnt == 63) begin
            m_als = !m_hl && (m_sel < 2);
            m_k   = (m_hl || m_sel < 2) ? 0 : 8 - m_sel;
        end
        if (hs) m_cnt = (m_cnt + 1) % 64;
        hlim = hs_is_xtal ? 1024 : 16;
        llim = ls_is_xtal ? 1024 : 2;
        if (md != 2'b00) begin m_hsc = 0; m_hsr = 0; end
        else if (hs && !m_hsr) begin m_hsc++; if (m_hsc == hlim) m_hsr = 1; end
        if (md[1]) begin m_lsc = 0; m_lsr = 0; end
        else if (ls && !m_lsr) begin m_lsc++; if (m_lsc == llim) m_lsr = 1; end
        if (wr) begin
            m_sel = wd[7:5]; m_fast = wd[4]; m_idle = wd[1]; m_hl = wd[0];
        end
    endtask

    // Monitor: pop and compare just after each drive.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                n_vec++;
                if (sys_en !== e.en || reg_rdata !== e.rd) begin
                    n_bad++;
                    $display("FAIL %s: sys_en=%b rdata=%h expected sys_en=%b rdata=%h at %0t",
                             e.req, sys_en, reg_rdata, e.en, e.rd, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset value
        for (int i = 0; i < 3; i++) step(0, 0, 2'b00, 0, 8'h00, "R1");
        // R5: high-speed RC settles after 16 ticks
        for (int i = 0; i < 20; i++) step(1, 0, 2'b00, 0, 8'h00, "R5");
        // R6: low-speed RC settles after 2 ticks
        for (int i = 0; i < 6; i++) step(0, 1, 2'b00, 0, 8'h00, "R6");
        // R2: flag bits ignore writes
        step(0, 0, 2'b00, 1, 8'hFF, "R2");
        step(0, 0, 2'b00, 0, 8'h00, "R2");
        step(0, 0, 2'b00, 1, 8'h00, "R2");
        step(0, 0, 2'b00, 1, 8'h13, "R2");
        step(0, 0, 2'b00, 0, 8'h00, "R2");
        // R3 / R4: each select code, switch at counter wrap
        for (int s = 0; s < 8; s++) begin
            step(0, 0, 2'b00, 1, {s[2:0], 5'b00000}, "R4");
            for (int i = 0; i < 140; i++)
                step(1, (i % 3) == 0, 2'b00, 0, 8'h00, (i < 64) ? "R4" : "R3");
        end
        step(0, 0, 2'b00, 1, 8'h03, "R4");
        for (int i = 0; i < 150; i++)
            step(($urandom_range(0, 9) < 7), ($urandom_range(0, 3) == 0), 2'b00, 0, 8'h00, "R3");
        // R10: idle stops high-speed only; both sleep codes stop both
        for (int i = 0; i < 10; i++) step(1, 1, 2'b01, 0, 8'h00, "R10");
        for (int i = 0; i < 10; i++) step(1, 1, 2'b10, 0, 8'h00, "R9");
        for (int i = 0; i < 5; i++)  step(1, 1, 2'b11, 0, 8'h00, "R10");
        // R7: no enable until the source settles again
        for (int i = 0; i < 25; i++) step(1, 1, 2'b00, 0, 8'h00, "R7");
        // R8: crystal high-speed with fast wake
        step(0, 0, 2'b10, 1, 8'h13, "R8");
        hs_is_xtal = 1'b1;
        for (int i = 0; i < 3; i++) step(0, 0, 2'b10, 0, 8'h00, "R8");
        for (int i = 0; i < 1100; i++) step(1, (i % 2) == 0, 2'b00, 0, 8'h00, "R8");
        // R7: same wake without fast wake stays silent
        step(0, 0, 2'b10, 1, 8'h03, "R7");
        for (int i = 0; i < 40; i++) step(1, 1, 2'b00, 0, 8'h00, "R7");
        // R6: crystal low-speed, system on low-speed clock
        step(0, 0, 2'b10, 1, 8'h02, "R6");
        ls_is_xtal = 1'b1;
        for (int i = 0; i < 1100; i++) step((i % 2) == 1, 1, 2'b00, 0, 8'h00, "R6");
        step(0, 0, 2'b00, 0, 8'h00, "R6");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule